// File: doc/BRIEF.md
# Atomic Set/Clear GPIO Bank

A bank of up to eight general-purpose pins controlled through one 32-bit register on a simple synchronous register bus. Software never reads the register to change it. Each write carries one-hot action bits. Per pin, one bit drives the output latch low and one drives it high. Two more bits switch the pin to output or to input. A zero bit does nothing. This lets independent agents on different pins update the bank with plain writes, with no read-modify-write and no lock.

Reading the same register returns the live pad level of every pin, passed through a two-flop synchronizer. The level sits in the odd bit of each pin's data pair. The stored latch and direction state are driven out on the pin ports and are never returned on reads. The bank size is a parameter: an 8-pin bank fills all data and direction fields of the word, and a 4-pin bank uses only the lower half of each field. The register answers at a single parameterised address.

Top module: `gpio_action_bank`

## Requirements
- R1: A register write with bit 2n = 1 (n < NUM_PINS) makes gpio_out_o[n] 0 from the clock edge that takes the write.
- R2: A register write with bit 2n+1 = 1 and bit 2n = 0 makes gpio_out_o[n] 1 from the clock edge that takes the write.
- R3: When bits 2n and 2n+1 are both 1 in one write, the clear wins and gpio_out_o[n] becomes 0.
- R4: A register write with bit 2n+16 = 1 and bit 2n+17 = 0 makes gpio_oe_o[n] 1 (pin drives).
- R5: A register write with bit 2n+17 = 1 makes gpio_oe_o[n] 0 (pin is an input), also when bit 2n+16 is 1 in the same write.
- R6: A pin whose four action bits are all 0 in a write keeps both gpio_out_o[n] and gpio_oe_o[n] unchanged.
- R7: While rst_ni is low and after its release, before any write, all gpio_out_o and gpio_oe_o bits are 0, and the read data is 0 during reset.
- R8: Read data bit 2n+1 equals gpio_in_i[n] as sampled two clock edges earlier. The pad level is returned whatever the pin direction is.
- R9: Read data bits that hold no pin level are 0. These are all even bits, bits 16..31, and the odd bits of pins at or above NUM_PINS. Write bits belonging to pins at or above NUM_PINS have no effect.
- R10: When addr_i differs from REG_ADDR, writes change nothing and rdata_o is 0.
- R11: A single write with set bit 2n+1 and output bit 2n+16 makes gpio_oe_o[n] and gpio_out_o[n] both 1 on the same edge, so the pin never drives a stale level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Register address |
| we_i | input | 1 | Write enable, taken at the rising clock edge |
| wdata_i | input | 32 | Write data with action bits |
| rdata_o | output | 32 | Read data with synchronized pad levels |
| gpio_out_o | output | NUM_PINS | Output latch per pin |
| gpio_oe_o | output | NUM_PINS | Output enable per pin, 1 = drive |
| gpio_in_i | input | NUM_PINS | Pad level per pin, may be asynchronous |

## Verification
The assertions assume that address, write enable and write data are stable around each rising edge and change only between edges. They also assume that reset is applied once before the bank is used. Pad inputs are allowed to change at any time, because only the synchronizer output is related to them. The bench changes every input on the falling edge. It models the pad as a loopback that returns the latch value when a pin drives and a bench-chosen level when it does not. It waits two edges after any pad change before it compares read data.

// File: rtl/gpio_bank_pkg.sv
`timescale 1ns/1ps
package gpio_bank_pkg;
  localparam int unsigned REG_W    = 32;
  localparam int unsigned MAX_PINS = 8;
  localparam int unsigned DIR_OFS  = 16;

  typedef struct packed {
    logic clr;
    logic set;
    logic mk_out;
    logic mk_in;
  } pin_act_t;

  // bits a write may act on for a bank of np pins
  function automatic logic [REG_W-1:0] act_mask(int unsigned np);
    logic [REG_W-1:0] m;
    m = '0;
    for (int unsigned i = 0; i < MAX_PINS; i++) begin
      if (i < np) begin
        m[2*i]           = 1'b1;
        m[2*i+1]         = 1'b1;
        m[2*i+DIR_OFS]   = 1'b1;
        m[2*i+DIR_OFS+1] = 1'b1;
      end
    end
    return m;
  endfunction

  // bits that carry a pin level on read
  function automatic logic [REG_W-1:0] lvl_mask(int unsigned np);
    logic [REG_W-1:0] m;
    m = '0;
    for (int unsigned i = 0; i < MAX_PINS; i++) begin
      if (i < np) m[2*i+1] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/gpio_pin_ctrl.sv
`timescale 1ns/1ps
module gpio_pin_ctrl
  import gpio_bank_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  pin_act_t act_i,
  output logic     out_o,
  output logic     oe_o
);
  logic out_q, oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      // clear dominates set, input dominates output
      if (act_i.clr)      out_q <= 1'b0;
      else if (act_i.set) out_q <= 1'b1;
      if (act_i.mk_in)       oe_q <= 1'b0;
      else if (act_i.mk_out) oe_q <= 1'b1;
    end
  end

  assign out_o = out_q;
  assign oe_o  = oe_q;

  AST_CLR_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i.clr |=> !out_q); // R1
  AST_SET_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_i.set && !act_i.clr) |=> out_q); // R2
  AST_CLR_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_i.set && act_i.clr) |=> !out_q); // R3
  AST_DIR_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_i.mk_out && !act_i.mk_in) |=> oe_q); // R4
  AST_DIR_IN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i.mk_in |=> !oe_q); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_i == '0) |=> ($stable(out_q) && $stable(oe_q))); // R6
  AST_DRIVE_FRESH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act_i.set && act_i.mk_out && !act_i.clr && !act_i.mk_in) |=> (out_q && oe_q)); // R11
endmodule

// File: rtl/gpio_in_sync.sv
`timescale 1ns/1ps
module gpio_in_sync #(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] pin_i,
  output logic [WIDTH-1:0] lvl_o
);
  logic [WIDTH-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= pin_i;
      sync_q <= meta_q;
    end
  end

  assign lvl_o = sync_q;

  // edges since reset, for the latency check only
  logic [1:0] age_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              age_q <= 2'd0;
    else if (age_q != 2'd2)   age_q <= age_q + 2'd1;
  end

  AST_SYNC_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd2) |-> (lvl_o == $past(pin_i, 2))); // R8
endmodule

// File: rtl/gpio_rd_pack.sv
`timescale 1ns/1ps
module gpio_rd_pack
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_PINS = 8
) (
  input  logic                hit_i,
  input  logic [NUM_PINS-1:0] lvl_i,
  output logic [REG_W-1:0]    rdata_o
);
  always_comb begin
    rdata_o = '0;
    if (hit_i) begin
      for (int unsigned i = 0; i < NUM_PINS; i++) rdata_o[2*i+1] = lvl_i[i];
    end
  end
endmodule

// File: rtl/gpio_action_bank.sv
`timescale 1ns/1ps
module gpio_action_bank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_PINS = 8,
  parameter int unsigned ADDR_W   = 12,
  parameter logic [ADDR_W-1:0] REG_ADDR = 12'h040
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                we_i,
  input  logic [REG_W-1:0]    wdata_i,
  output logic [REG_W-1:0]    rdata_o,
  output logic [NUM_PINS-1:0] gpio_out_o,
  output logic [NUM_PINS-1:0] gpio_oe_o,
  input  logic [NUM_PINS-1:0] gpio_in_i
);
  localparam logic [REG_W-1:0] WR_MASK  = act_mask(NUM_PINS);
  localparam logic [REG_W-1:0] LVL_MASK = lvl_mask(NUM_PINS);

  logic                rd_hit, wr_hit;
  logic [NUM_PINS-1:0] lvl;
  logic                unused_bits;

  assign rd_hit      = (addr_i == REG_ADDR);
  assign wr_hit      = we_i && rd_hit;
  assign unused_bits = ^(wdata_i & ~WR_MASK);

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    pin_act_t act;
    assign act.clr    = wr_hit & wdata_i[2*i];
    assign act.set    = wr_hit & wdata_i[2*i+1];
    assign act.mk_out = wr_hit & wdata_i[2*i+DIR_OFS];
    assign act.mk_in  = wr_hit & wdata_i[2*i+DIR_OFS+1];

    gpio_pin_ctrl i_pin (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .act_i  (act),
      .out_o  (gpio_out_o[i]),
      .oe_o   (gpio_oe_o[i])
    );
  end

  gpio_in_sync #(.WIDTH(NUM_PINS)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (gpio_in_i),
    .lvl_o  (lvl)
  );

  gpio_rd_pack #(.NUM_PINS(NUM_PINS)) i_rd (
    .hit_i   (rd_hit),
    .lvl_i   (lvl),
    .rdata_o (rdata_o)
  );

  AST_RD_UNUSED_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_o & ~LVL_MASK) == '0); // R9
  AST_MISS_RD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_hit |-> (rdata_o == '0)); // R10
  AST_MISS_NO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_hit |=> ($stable(gpio_out_o) && $stable(gpio_oe_o))); // R10
  AST_RESET_IDLE: assert property (@(posedge clk_i)
    !rst_ni |-> (gpio_out_o == '0 && gpio_oe_o == '0)); // R7
endmodule

// File: tb/test_gpio_action_bank.sv
`timescale 1ns/1ps
module test_gpio_action_bank;
  localparam logic [11:0] RA = 12'h040;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [11:0] a_addr = RA, b_addr = RA;
  logic        a_we = 1'b0, b_we = 1'b0;
  logic [31:0] a_wd = '0, b_wd = '0;
  logic [31:0] a_rd, b_rd;
  logic [7:0]  a_out, a_oe, a_in;
  logic [3:0]  b_out, b_oe, b_in;

  logic [7:0] m_out [2];
  logic [7:0] m_oe  [2];
  logic [7:0] ext   [2];

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  assign a_in = (ext[0] & ~a_oe) | (a_out & a_oe);
  assign b_in = (ext[1][3:0] & ~b_oe) | (b_out & b_oe);

  gpio_action_bank #(.NUM_PINS(8), .ADDR_W(12), .REG_ADDR(RA)) i_gpio_action_bank (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(a_addr), .we_i(a_we), .wdata_i(a_wd),
    .rdata_o(a_rd), .gpio_out_o(a_out), .gpio_oe_o(a_oe), .gpio_in_i(a_in));

  gpio_action_bank #(.NUM_PINS(4), .ADDR_W(12), .REG_ADDR(RA)) i_gpio_action_bank_small (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(b_addr), .we_i(b_we), .wdata_i(b_wd),
    .rdata_o(b_rd), .gpio_out_o(b_out), .gpio_oe_o(b_oe), .gpio_in_i(b_in));

  function automatic int np(int s);
    return (s == 0) ? 8 : 4;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // model: clear beats set, input beats output, only pins below np
  task automatic apply(int s, logic [31:0] d, bit hit);
    if (!hit) return;
    for (int n = 0; n < np(s); n++) begin
      if (d[2*n])         m_out[s][n] = 1'b0;
      else if (d[2*n+1])  m_out[s][n] = 1'b1;
      if (d[2*n+17])      m_oe[s][n] = 1'b0;
      else if (d[2*n+16]) m_oe[s][n] = 1'b1;
    end
  endtask

  function automatic logic [31:0] exp_rd(int s);
    logic [31:0] r = '0;
    for (int n = 0; n < np(s); n++)
      r[2*n+1] = m_oe[s][n] ? m_out[s][n] : ext[s][n];
    return r;
  endfunction

  task automatic wr(int s, logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    if (s == 0) begin a_addr = a; a_we = 1'b1; a_wd = d; end
    else        begin b_addr = a; b_we = 1'b1; b_wd = d; end
    @(negedge clk);
    a_we = 1'b0; b_we = 1'b0; a_addr = RA; b_addr = RA;
    apply(s, d, a == RA);
    #1;
  endtask

  task automatic chk_state(int s, string req);
    logic [7:0] o, e;
    o = (s == 0) ? a_out : {4'b0, b_out};
    e = (s == 0) ? a_oe  : {4'b0, b_oe};
    chk({req, " out"}, {24'b0, o}, {24'b0, m_out[s]});
    chk({req, " oe"},  {24'b0, e}, {24'b0, m_oe[s]});
  endtask

  task automatic chk_read(int s, string req);
    repeat (2) @(negedge clk);
    #1;
    chk(req, (s == 0) ? a_rd : b_rd, exp_rd(s));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int s = 0; s < 2; s++) begin m_out[s] = '0; m_oe[s] = '0; ext[s] = '0; end
    ext[0] = 8'hA5; ext[1] = 8'h0C;
    repeat (4) @(negedge clk);
    #1;
    chk("R7 rd in reset", a_rd, 32'h0);
    chk("R7 oe in reset", {24'b0, a_oe}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk_state(0, "R7 after reset");
    chk_state(1, "R7 after reset small");
    chk_read(0, "R8 input levels after reset");

    // R11: level and direction in one word for pin 3
    wr(0, RA, (32'h1 << 7) | (32'h1 << 22));
    chk("R11 pin3 drives high", {30'b0, a_oe[3], a_out[3]}, 32'h3);
    chk_state(0, "R2/R4 set+out");
    chk_read(0, "R8 loopback driven pin");
    // R3: clear beats set
    wr(0, RA, (32'h1 << 6) | (32'h1 << 7));
    chk("R3 clear wins", {31'b0, a_out[3]}, 32'h0);
    // R1: clear alone after a set on pin 0
    wr(0, RA, 32'h2);
    wr(0, RA, 32'h1);
    chk("R1 clear pin0", {31'b0, a_out[0]}, 32'h0);
    // R5: input beats output
    wr(0, RA, (32'h1 << 22) | (32'h1 << 23));
    chk("R5 input wins", {31'b0, a_oe[3]}, 32'h0);
    // R6: zero word leaves all state alone
    wr(0, RA, 32'h0000_FFFF & 32'h0000_0AAA);
    wr(0, RA, 32'h0055_0000);
    wr(0, RA, 32'h0);
    chk_state(0, "R6 zero write");
    // R9: bits above a 4-pin bank
    wr(1, RA, 32'h0005_00AA);
    wr(1, RA, 32'hFF00_FF00);
    chk_state(1, "R9 beyond bank ignored");
    chk_read(1, "R9 unused read bits zero");
    // R10: other address
    wr(0, RA ^ 12'h004, 32'h00FF_0055);
    chk_state(0, "R10 miss write ignored");
    @(negedge clk); a_addr = RA ^ 12'h004; #1;
    chk("R10 miss read zero", a_rd, 32'h0);
    a_addr = RA;
    // R8: two-edge latency on input pin 0
    wr(0, RA, 32'h0002_0000);
    chk_read(0, "R8 pin0 input");
    @(negedge clk); ext[0][0] = ~ext[0][0];
    @(negedge clk); #1;
    chk("R8 not yet after one edge", {31'b0, a_rd[1]}, {31'b0, ~ext[0][0]});
    @(negedge clk); #1;
    chk("R8 visible after two edges", {31'b0, a_rd[1]}, {31'b0, ext[0][0]});

    // random mix, R1..R6 R9 R10 against model
    for (int it = 0; it < 600; it++) begin
      int s;
      logic [11:0] ad;
      logic [31:0] d;
      s = int'($urandom % 2);
      d = $urandom;
      if ($urandom % 4 == 0) d = d & ~($urandom);
      ad = ($urandom % 8 == 0) ? (RA ^ 12'h010) : RA;
      if ($urandom % 3 == 0) begin @(negedge clk); ext[s] = 8'($urandom); end
      wr(s, ad, d);
      chk_state(s, "R1-6/R10 random");
      chk_read(s, "R8/R9 random read");
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule